// File: doc/BRIEF.md
# Five-State Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary loop of five codes. The state bits are named C (bit 2), B (bit 1) and A (bit 0). Written as CBA, the loop is 000, 100, 111, 010, 011 and then back to 000. The counter advances one step on every rising clock edge. It has no load, no enable and no direction input.

The three codes outside the loop are 001, 101 and 110. Each one has a fixed successor, so a counter that starts in one of them returns to the loop in a known way. A registered flag, `valid_o`, tells downstream logic whether the present code is one of the five loop codes.

A synchronous active-high reset loads the code set by the parameter `RESET_CODE`, which defaults to 000. Setting this parameter to an unused code lets an instance start outside the loop, so that the recovery path can be tested.

Top module: `seq5_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `RESET_CODE` (000 by default), and `valid_o` shows whether that code is a loop code.
- R2: With `rst` low, a counter on the loop moves one step per edge in the order 000 → 100 → 111 → 010 → 011 → 000.
- R3: From the unused code 001, the next state is 111.
- R4: From the unused code 101, the next state is 110.
- R5: From the unused code 110, the next state is 011.
- R6: `valid_o` is 1 exactly when `state_o` is one of 000, 100, 111, 010 or 011. It changes on the same edge as `state_o`.
- R7: From any unused code, `valid_o` becomes 1 within two rising edges with `rst` low.
- R8: Asserting `rst` at any point in the loop overrides the step. The counter is at `RESET_CODE` after that edge.
- R9: The loop has a period of exactly five edges: after five steps from a loop code, the state is the same code again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| state_o | output | 3 | Present state; bit 2 = C, bit 1 = B, bit 0 = A |
| valid_o | output | 1 | 1 when the present state is a loop code |

## Verification
Both outputs come straight from flip-flops. Each result is therefore due exactly one rising edge after the stimulus that causes it: the reset level for R1 and R8, and the present code for every step. For this reason the bench changes `rst` only on falling edges, and reads both outputs on the next falling edge after each rising edge. The check of R7 counts those edges one at a time. The unused-code successors are checked on extra instances whose `RESET_CODE` is 001, 101 or 110. Reset places each of them in its unused code, and the bench checks the first steps after reset is released.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  localparam int STATE_W  = 3;
  localparam int LOOP_LEN = 5;

  typedef logic [STATE_W-1:0] code_t;

  // Loop codes in stepping order (CBA).
  localparam code_t LOOP_CODES [LOOP_LEN] = '{3'b000, 3'b100, 3'b111, 3'b010, 3'b011};

  function automatic logic in_loop(code_t c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LOOP_LEN; i++) begin
      if (c == LOOP_CODES[i]) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/seq5_state_reg.sv
module seq5_state_reg #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/seq5_next.sv
module seq5_next
  import seq5_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  logic c, b, a;
  assign c = cur[2];
  assign b = cur[1];
  assign a = cur[0];

  // D-input equations, reduced with the unused codes steered to fixed successors.
  assign nxt[2] = ~b;
  assign nxt[1] = c | (b ^ a);
  assign nxt[0] = (~c & ~b & a) | (~a & (b | c));
endmodule

// File: rtl/seq5_member.sv
module seq5_member
  import seq5_pkg::*;
(
  input  code_t code,
  output logic  hit
);
  logic [LOOP_LEN-1:0] match;
  for (genvar i = 0; i < LOOP_LEN; i++) begin : g_cmp
    assign match[i] = (code == LOOP_CODES[i]);
  end
  assign hit = |match;
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
  import seq5_pkg::*;
#(
  parameter logic [2:0] RESET_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] state_o,
  output logic       valid_o
);
  localparam logic RESET_VALID = in_loop(RESET_CODE);

  code_t cur_q, nxt_d;
  logic  nxt_hit;

  seq5_next u_next (
    .cur (cur_q),
    .nxt (nxt_d)
  );

  seq5_member u_member (
    .code (nxt_d),
    .hit  (nxt_hit)
  );

  seq5_state_reg #(.W(STATE_W), .RST_VAL(RESET_CODE)) u_state (
    .clk (clk),
    .rst (rst),
    .d   (nxt_d),
    .q   (cur_q)
  );

  // The flag is registered from the next code, so it lines up with state_o.
  seq5_state_reg #(.W(1), .RST_VAL(RESET_VALID)) u_valid (
    .clk (clk),
    .rst (rst),
    .d   (nxt_hit),
    .q   (valid_o)
  );

  assign state_o = cur_q;
endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk #(
  parameter logic [2:0] RESET_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       valid_o
);
  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (state_o == RESET_CODE));

  assert_loop_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b000) |=> (state_o == 3'b100));

  assert_loop_mid_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b111) |=> (state_o == 3'b010));

  assert_from_001_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b001) |=> (state_o == 3'b111));

  assert_from_101_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b101) |=> (state_o == 3'b110));

  assert_from_110_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b110) |=> (state_o == 3'b011));

  assert_flag_match_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o == !(state_o == 3'b001 || state_o == 3'b101 || state_o == 3'b110));

  assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |=> (valid_o || state_o == 3'b110));

  assert_loop_closed_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);
endmodule

bind seq5_counter seq5_counter_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .state_o (state_o),
  .valid_o (valid_o)
);

// File: tb/seq5_counter_tb.sv
module seq5_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   total = 0;
  int   bad   = 0;

  logic [2:0] st0, st1, st5, st6;
  logic       v0, v1, v5, v6;

  always #4 clk = ~clk;

  seq5_counter u_dut (.clk(clk), .rst(rst), .state_o(st0), .valid_o(v0));
  seq5_counter #(.RESET_CODE(3'b001)) u_dut_001 (.clk(clk), .rst(rst), .state_o(st1), .valid_o(v1));
  seq5_counter #(.RESET_CODE(3'b101)) u_dut_101 (.clk(clk), .rst(rst), .state_o(st5), .valid_o(v5));
  seq5_counter #(.RESET_CODE(3'b110)) u_dut_110 (.clk(clk), .rst(rst), .state_o(st6), .valid_o(v6));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One rising edge, then read on the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 default reset", {st0, v0}, 4'b0001);
    chk("R1 reset to 001", {st1, v1}, 4'b0010);
    chk("R1 reset to 101", {st5, v5}, 4'b1010);
    chk("R1 reset to 110", {st6, v6}, 4'b1100);
  endtask

  task automatic t_loop();
    logic [2:0] seq [5] = '{3'b100, 3'b111, 3'b010, 3'b011, 3'b000};
    do_reset();
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R2 loop order", {1'b0, st0}, {1'b0, seq[i % 5]});
      chk("R6 flag on loop", {3'b0, v0}, 4'b0001);
    end
    chk("R9 period five", {1'b0, st0}, 4'b0000);
  endtask

  task automatic t_unused();
    do_reset();
    step();
    chk("R3 001 to 111", {st1, v1}, 4'b1111);
    chk("R4 101 to 110", {st5, v5}, 4'b1100);
    chk("R5 110 to 011", {st6, v6}, 4'b0111);
    chk("R7 001 recovers in one", {3'b0, v1}, 4'b0001);
    step();
    chk("R5 chain 110 to 011", {st5, v5}, 4'b0111);
    chk("R7 101 recovers in two", {3'b0, v5}, 4'b0001);
    chk("R2 after 001 entry", {1'b0, st1}, 4'b0010);
    chk("R2 after 110 entry", {1'b0, st6}, 4'b0000);
  endtask

  task automatic t_mid_reset();
    do_reset();
    step();
    step();
    chk("R2 two steps", {1'b0, st0}, 4'b0111);
    @(negedge clk);
    rst = 1'b1;
    step();
    chk("R8 reset overrides step", {st0, v0}, 4'b0001);
    chk("R8 unused instance reloads", {st6, v6}, 4'b1100);
    rst = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_loop();
        t_unused();
        t_mid_reset();
      end
      begin
        repeat (2000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule